// File: doc/BRIEF.md
# Byte-wide SPI master/slave port

This block moves one byte at a time over a four-wire synchronous serial link. A control register sets its role. As master it makes the serial clock from the system clock and drives it out. As slave it follows a serial clock from another device, and only while that device holds the active-low select low. Both roles send one byte and take in one byte at the same time. Software picks the clock polarity, the clock phase and the bit order. In master mode it also picks one of four bit rates.

Software works through a small register port with three addresses. Address 0 holds the control fields. Address 1 holds the flags. Address 2 is the data register: a write loads the byte to send, and a read returns the byte last received. In master mode a write to address 2 starts a transfer, and the clock stops after eight bits. A done flag reports each finished byte. A collision flag reports a data write that arrived while a byte was still moving. The interrupt output needs the done flag and two separate enables.

Top module: `spi_port`

## Requirements
- R1: After reset the control register and the flag register read as 0, `irq` is 0 and `sck_o` is 0.
- R2: In master mode (control bit 4 = 1) a data write while idle produces exactly 16 SCK edges, and then stops. The done flag (status bit 0) is set 16×H clock cycles after the edge that takes the write. H is 2, 8, 32 or 64 for a rate field (control bits 1:0) of 0, 1, 2 or 3. This gives an SCK period of 4, 16, 64 or 128 system clocks.
- R3: Control bit 5 = 1 sends and receives the least significant bit first. Control bit 5 = 0 sends and receives the most significant bit first. This holds on both data lines and in both roles.
- R4: Control bit 3 (CPOL) is the idle level of `sck_o`. Control bit 2 (CPHA) = 0 samples on the first, third, … edges, with the first bit valid before the first edge. CPHA = 1 samples on the second, fourth, … edges.
- R5: When the done flag is set, a read of address 2 returns the byte received in that transfer.
- R6: Writing 0 to status bit 0 clears the done flag, and writing 0 to status bit 1 clears the collision flag. Writing 1 to either bit leaves that flag unchanged.
- R7: A data write during a transfer sets the collision flag (status bit 1). It changes neither the bits still being sent nor the byte being received.
- R8: `irq` is 1 only when the done flag, control bit 6 and `port_ie` are all 1.
- R9: In slave mode (control bit 4 = 0) and with `ss_n_i` low, the block shifts the loaded byte out on `miso_o`. It takes `mosi_i` in on the edges set by CPOL/CPHA, and it sets the done flag after 16 edges.
- R10: While `ss_n_i` is high, a slave ignores `sck_i` and `mosi_i`. Edges seen then neither advance the transfer, nor shift the outgoing byte, nor set any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 flags, 2 data |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| port_ie | input | 1 | Serial-port interrupt enable |
| sck_o | output | 1 | Serial clock driven in master mode |
| mosi_o | output | 1 | Serial data out in master mode |
| miso_i | input | 1 | Serial data in for master mode |
| sck_i | input | 1 | External serial clock in slave mode |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_o | output | 1 | Serial data out in slave mode |
| ss_n_i | input | 1 | Active-low slave select |
| irq | output | 1 | Interrupt request |

## Verification
In master mode the bench counts the cycles from the edge that takes the data write to the first cycle in which the done flag reads 1, and this count must equal 16×H. It samples `sck_o` and `mosi_o` on the falling clock edge that follows each SCK change, so the result does not depend on the order of processes at the active edge. Between the same edges it acts as the far-end slave and drives `miso_i`. In slave mode each external SCK edge takes effect about three system clocks later: two synchronizer stages and one edge register. The bench therefore holds each SCK half-period for 8 clocks, and it reads `miso_o` only at the end of a half-period.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;
  localparam int DIV_W  = 7;
  localparam int SYNC_STAGES = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

  // control register, bit 6 down to bit 0
  typedef struct packed {
    logic       irq_en;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // system clocks per SCK half period: rates give /4, /16, /64, /128
  function automatic logic [DIV_W-1:0] half_period(input logic [1:0] rate);
    int unsigned expo;
    expo = (rate == 2'd3) ? 6 : (2 * int'(rate) + 1);
    return DIV_W'(1) << expo;
  endfunction
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] limit;

  assign limit = half_period(rate) - DIV_W'(1);
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                 cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W      = 3,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{INIT}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] din,
  input  logic         step,
  input  logic         abort,
  input  logic         cpha,
  input  logic         lsb_first,
  input  logic         sin,
  output logic         sout,
  output logic [N-1:0] rx,
  output logic         done,
  output logic         active
);
  localparam int EDGES = 2 * N;
  localparam int CW    = $clog2(EDGES);

  logic [CW-1:0] edge_q;
  logic [N-1:0]  tx_q;
  logic [N-1:0]  rx_q;
  logic          is_sample;
  logic          is_shift;

  // even edge index = leading edge
  assign is_sample = cpha ? edge_q[0] : ~edge_q[0];
  assign is_shift  = ~is_sample && !(cpha && edge_q == '0);
  assign done      = step && (edge_q == CW'(EDGES - 1));
  assign active    = (edge_q != '0);
  assign sout      = lsb_first ? tx_q[0] : tx_q[N-1];
  assign rx        = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      if (abort || load)  edge_q <= '0;
      else if (done)      edge_q <= '0;
      else if (step)      edge_q <= edge_q + CW'(1);

      if (load)                      tx_q <= din;
      else if (step && is_shift)     tx_q <= lsb_first ? (tx_q >> 1) : (tx_q << 1);

      if (step && is_sample && !abort)
        rx_q <= lsb_first ? {sin, rx_q[N-1:1]} : {rx_q[N-2:0], sin};
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              port_ie,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  input  logic              sck_i,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic              ss_n_i,
  output logic              irq
);
  ctrl_t             ctrl_q;
  logic              spif_q, wcol_q, busy_q, sck_q, sck_d;
  logic              tick, step, abort, sin, sout;
  logic              xfer_done, core_active, xfer_busy;
  logic              data_wr, stat_wr, collide, load;
  logic              is_master, cpol_w;
  logic              ss_sync, mosi_sync, sck_sync, slave_edge;
  logic [BYTE_W-1:0] rx_byte;

  assign is_master = ctrl_q.master;
  assign cpol_w    = ctrl_q.cpol;

  assign data_wr   = reg_we && (reg_addr == ADDR_DATA);
  assign stat_wr   = reg_we && (reg_addr == ADDR_STAT);
  assign xfer_busy = is_master ? busy_q : core_active;
  assign collide   = data_wr && xfer_busy;
  assign load      = data_wr && !xfer_busy;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ss_n_i, mosi_i, sck_i}),
    .q({ss_sync, mosi_sync, sck_sync})
  );

  spi_rate_gen u_rate (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .rate(ctrl_q.rate), .tick(tick)
  );

  assign slave_edge = sck_sync ^ sck_d;
  assign step  = is_master ? (busy_q && tick) : (slave_edge && !ss_sync);
  assign abort = !is_master && ss_sync;
  assign sin   = is_master ? miso_i : mosi_sync;

  spi_shift_core #(.N(BYTE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(load), .din(reg_wdata), .step(step),
    .abort(abort), .cpha(ctrl_q.cpha), .lsb_first(ctrl_q.lsb_first),
    .sin(sin), .sout(sout), .rx(rx_byte), .done(xfer_done),
    .active(core_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      spif_q <= 1'b0;
      wcol_q <= 1'b0;
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      sck_d  <= 1'b0;
    end else begin
      sck_d <= sck_sync;
      if (reg_we && reg_addr == ADDR_CTRL)
        ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);

      if (!is_master)              busy_q <= 1'b0;
      else if (load)               busy_q <= 1'b1;
      else if (xfer_done)          busy_q <= 1'b0;

      if (!busy_q)                 sck_q <= cpol_w;
      else if (tick)               sck_q <= ~sck_q;

      if (xfer_done)               spif_q <= 1'b1;
      else if (stat_wr && !reg_wdata[0]) spif_q <= 1'b0;

      if (collide)                 wcol_q <= 1'b1;
      else if (stat_wr && !reg_wdata[1]) wcol_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = {{(BYTE_W-CTRL_W){1'b0}}, ctrl_q};
      ADDR_STAT: reg_rdata = {{(BYTE_W-2){1'b0}}, wcol_q, spif_q};
      ADDR_DATA: reg_rdata = rx_byte;
      default:   reg_rdata = '0;
    endcase
  end

  assign sck_o  = sck_q;
  assign mosi_o = sout;
  assign miso_o = sout;
  assign irq    = spif_q && ctrl_q.irq_en && port_ie;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic clk,
  input logic rst_n,
  input logic is_master,
  input logic cpol_w,
  input logic busy_q,
  input logic sck_o,
  input logic xfer_done,
  input logic spif_q,
  input logic wcol_q,
  input logic collide,
  input logic ss_sync,
  input logic core_active,
  input logic port_ie,
  input logic irq
);
  assert_collide_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> wcol_q);

  assert_collide_keeps_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && is_master && !xfer_done) |=> busy_q);

  assert_stop_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && xfer_done) |=> !busy_q);

  assert_done_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spif_q) |-> $past(xfer_done));

  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && !busy_q && $past(!busy_q) && $stable(cpol_w)) |-> (sck_o == cpol_w));

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_ie || !spif_q) |-> !irq);

  assert_deselect_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && ss_sync) |=> !core_active);
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .is_master(is_master), .cpol_w(cpol_w),
  .busy_q(busy_q), .sck_o(sck_o), .xfer_done(xfer_done), .spif_q(spif_q),
  .wcol_q(wcol_q), .collide(collide), .ss_sync(ss_sync),
  .core_active(core_active), .port_ie(port_ie), .irq(irq)
);

// File: tb/spi_port_test.sv
module spi_port_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_addr;
  logic       reg_we;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       port_ie, sck_o, mosi_o, miso_i, sck_i, mosi_i, miso_o, ss_n_i, irq;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] sb_q[$];

  always #4 clk = ~clk;

  spi_port uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_ie(port_ie),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .sck_i(sck_i),
    .mosi_i(mosi_i), .miso_o(miso_o), .ss_n_i(ss_n_i), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic pick(input logic [7:0] b, input int k, input logic lsb);
    return lsb ? b[k] : b[7-k];
  endfunction

  function automatic int half_of(input int rate);
    return (rate == 3) ? 64 : (2 << (2 * rate));
  endfunction

  // master transfer; the bench plays the far-end slave
  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] sb, input int rate,
                             input logic cpha, input logic cpol, input logic lsb,
                             input logic collide);
    logic [7:0] got, rd;
    logic prev, seen;
    int k, n;
    reg_wr(2'd0, {1'b0, 1'b0, lsb, 1'b1, cpol, cpha, 2'(rate)});
    reg_wr(2'd1, 8'h00);
    @(negedge clk);
    check("R4 idle sck level", sck_o, cpol);
    sb_q.push_back(sb);
    miso_i = pick(sb, 0, lsb);
    reg_wr(2'd2, tx);
    reg_addr = 2'd1;
    prev = sck_o; k = 0; n = 0; got = '0; seen = 1'b0;
    while (!seen && n < 5000) begin
      @(negedge clk);
      n++;
      if (reg_we) begin reg_we = 1'b0; reg_addr = 2'd1; end
      if (sck_o != prev) begin
        prev = sck_o;
        if (cpha ? k[0] : !k[0]) begin
          if (lsb) got[k/2] = mosi_o; else got[7-k/2] = mosi_o;
        end else begin
          int i;
          i = cpha ? k/2 : (k+1)/2;
          if (i < 8) miso_i = pick(sb, i, lsb);
        end
        if (collide && k == 5) begin
          reg_addr = 2'd2; reg_wdata = ~tx; reg_we = 1'b1;
        end
        k++;
      end
      #1 seen = (reg_addr == 2'd1) && reg_rdata[0];
    end
    check("R2 cycles to done", n, 16 * half_of(rate));
    check("R2 sck edge count", k, 16);
    check("R3 mosi byte in chosen order", got, tx);
    @(negedge clk);
    check("R4 sck back at idle", sck_o, cpol);
    reg_rd(2'd2, rd);
    check("R5 received byte", rd, sb_q.pop_front());
    reg_rd(2'd1, rd);
    check("R7 collision flag", rd[1], collide);
  endtask

  // slave transfer; the bench plays the master at 8 clocks per half period
  task automatic slave_xfer(input logic [7:0] mtx, input logic [7:0] stx,
                            input logic cpha, input logic cpol, input logic lsb);
    logic [7:0] rd;
    reg_wr(2'd0, {1'b0, 1'b0, lsb, 1'b0, cpol, cpha, 2'b00});
    reg_wr(2'd1, 8'h00);
    sck_i = cpol; ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    reg_wr(2'd2, stx);
    @(negedge clk);
    ss_n_i = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (!cpha) begin
        mosi_i = pick(mtx, i, lsb);
        repeat (8) @(negedge clk);
        check("R9 slave miso bit", miso_o, pick(stx, i, lsb));
        sck_i = ~sck_i;
        repeat (8) @(negedge clk);
        sck_i = ~sck_i;
      end else begin
        sck_i = ~sck_i;
        repeat (8) @(negedge clk);
        mosi_i = pick(mtx, i, lsb);
        check("R9 slave miso bit", miso_o, pick(stx, i, lsb));
        sck_i = ~sck_i;
        repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    reg_rd(2'd1, rd);
    check("R9 slave done flag", rd[0], 1);
    reg_rd(2'd2, rd);
    check("R9 slave received byte", rd, mtx);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
    port_ie = 1'b1; miso_i = 1'b0; sck_i = 1'b0; mosi_i = 1'b0; ss_n_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    reg_rd(2'd0, rd); check("R1 control after reset", rd, 0);
    reg_rd(2'd1, rd); check("R1 flags after reset", rd, 0);
    check("R1 irq after reset", irq, 0);
    check("R1 sck after reset", sck_o, 0);

    // master: all four modes, all four rates, both orders
    master_xfer(8'hA5, 8'h3C, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    master_xfer(8'h81, 8'hC6, 1, 1'b1, 1'b0, 1'b1, 1'b0);
    master_xfer(8'h5E, 8'h17, 2, 1'b0, 1'b1, 1'b1, 1'b0);
    master_xfer(8'h0F, 8'hE2, 3, 1'b1, 1'b1, 1'b0, 1'b0);
    // R7 collision during a transfer
    master_xfer(8'h96, 8'h4B, 1, 1'b0, 1'b0, 1'b0, 1'b1);

    // R6 flag clearing: done=1, collision=1 now
    reg_wr(2'd1, 8'h02);
    reg_rd(2'd1, rd); check("R6 clear done keep collision", rd, 8'h02);
    reg_wr(2'd1, 8'h01);
    reg_rd(2'd1, rd); check("R6 clear collision, write 1 no set", rd, 8'h00);

    // R8 interrupt gating: make done=1 again
    master_xfer(8'h33, 8'hCC, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    port_ie = 1'b0;
    reg_wr(2'd0, 8'h50);
    @(negedge clk); check("R8 irq with port enable off", irq, 0);
    port_ie = 1'b1;
    reg_wr(2'd0, 8'h10);
    @(negedge clk); check("R8 irq with block enable off", irq, 0);
    reg_wr(2'd0, 8'h50);
    @(negedge clk); check("R8 irq with both enables", irq, 1);
    reg_wr(2'd1, 8'h00);
    @(negedge clk); check("R8 irq after done cleared", irq, 0);

    // slave transfers
    slave_xfer(8'hB4, 8'h69, 1'b0, 1'b0, 1'b0);
    slave_xfer(8'h2D, 8'hF0, 1'b1, 1'b1, 1'b1);

    // R10 deselected slave ignores SCK and MOSI
    reg_wr(2'd0, 8'h00);
    reg_wr(2'd1, 8'h00);
    ss_n_i = 1'b1; sck_i = 1'b0;
    reg_wr(2'd2, 8'h80);
    for (int e = 0; e < 16; e++) begin
      mosi_i = e[1];
      sck_i = ~sck_i;
      repeat (8) @(negedge clk);
    end
    reg_rd(2'd1, rd); check("R10 no flag while deselected", rd, 0);
    check("R10 outgoing byte not shifted", miso_o, 1);
    slave_xfer(8'h7E, 8'h81, 1'b0, 1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule